// File: doc/BRIEF.md
# FMCW Triangular-Sweep Range and Velocity Estimator

This block turns one pair of beat-frequency peaks into a target range and a radial velocity. The pair comes from the two halves of a triangular FMCW sweep: one value from the rising ramp and one from the falling ramp. The range comes from the mean of the two beats. The velocity comes from half their difference, because the Doppler shift lowers the beat on one ramp and raises it on the other. A flag marks a stationary target, which is a pair of equal beats.

Each beat word can be an FFT bin index or a frequency in hertz. For bin indices, the block converts to hertz by multiplying by the sample rate and shifting right by log2 of the FFT length. The supported lengths are 2048, 4096 and 8192 points. The scale factors are worked out beforehand from the sweep bandwidth, the sweep period and the wavelength. They enter the block as fixed-point constants, so no divider is needed. The datapath is a three-stage pipeline that can take a new pair on every cycle.

Top module: `fmcw_range_vel`

## Requirements
- R1: While `rst` is high at a rising edge, `in_ready`, `out_valid`, `out_range`, `out_vel` and `out_still` are all zero after that edge. After the first edge with `rst` low, `in_ready` is 1.
- R2: A pair is accepted at an edge where `in_valid` and `in_ready` are both 1. If a pair is accepted at edge n, `out_valid` is 1 for exactly the cycle after edge n+2. Pairs accepted on consecutive edges give results on consecutive cycles, in the same order. A reset at edge n+1 or n+2 cancels the result.
- R3: With `cfg_bin_mode`=0, each beat word is used as hertz unchanged. With `cfg_bin_mode`=1, each beat is converted to floor(word·`cfg_fs`/2^s). The shift s is 11, 12 or 13 for `cfg_pts` codes 0, 1 and 2; code 3 also uses 13. A converted value above 2^FW−1 saturates to 2^FW−1.
- R4: With u and d the converted up-ramp and down-ramp beats, `out_range` = floor((u+d)·`cfg_range_k`/2^(RFRAC+1)). The value saturates at 2^RW−1 and never wraps.
- R5: `out_vel` = floor((d−u)·`cfg_vel_k`/2^(VFRAC+1)) in two's complement. It is positive when the down-ramp beat is the larger one, which means the target is approaching. The value saturates to the range −2^(VW−1) … 2^(VW−1)−1.
- R6: `out_still` is 1 exactly when u equals d, and `out_vel` is then 0.
- R7: The mode, length code, sample rate and both scale constants are captured at acceptance. Changing them afterwards does not change the result of a pair already in flight.
- R8: `out_range`, `out_vel` and `out_still` change only in the cycle where `out_valid` is 1. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat pair present |
| in_ready | output | 1 | Block can accept a pair |
| in_f_up | input | FW | Beat on the rising ramp (hertz or bin) |
| in_f_dn | input | FW | Beat on the falling ramp (hertz or bin) |
| cfg_bin_mode | input | 1 | 1: inputs are bin indices |
| cfg_pts | input | 2 | FFT length code: 0=2048, 1=4096, 2 or 3=8192 |
| cfg_fs | input | SW | Sample rate in hertz |
| cfg_range_k | input | CW | Range scale c·Tm/(4B), RFRAC fraction bits |
| cfg_vel_k | input | CW | Velocity scale λ/2, VFRAC fraction bits |
| out_valid | output | 1 | Result present |
| out_range | output | RW | Range, unsigned, saturating |
| out_vel | output | VW | Radial velocity, signed, positive = approaching |
| out_still | output | 1 | Stationary target |

## Verification
The bench uses the default parameters: FW=20, SW=24, CW=24, RFRAC=VFRAC=16 and RW=VW=16. With 20-bit beats and 24-bit constants, full-scale inputs can drive `out_range` into saturation and `out_vel` into both signed limits. A 24-bit sample rate can push a converted bin index past the 20-bit beat width, which tests the clamp in R3. At these widths the bench can hold every product in a 64-bit integer, so it computes each expected value exactly for all four length codes.

// File: rtl/fmcw_rv_pkg.sv
package fmcw_rv_pkg;

  typedef enum logic [1:0] {
    PTS_2K  = 2'd0,
    PTS_4K  = 2'd1,
    PTS_8K  = 2'd2,
    PTS_8KB = 2'd3
  } pts_sel_e;

  // log2 of FFT length for a length code; the spare code maps to 8192
  function automatic int unsigned pts_shift(input logic [1:0] code);
    case (pts_sel_e'(code))
      PTS_2K:  return 11;
      PTS_4K:  return 12;
      default: return 13;
    endcase
  endfunction

endpackage

// File: rtl/fmcw_bin_conv.sv
// Stage 1 lane: bin index or hertz to hertz, clamped to FW bits
module fmcw_bin_conv #(
  parameter int FW = 20,
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bin_mode,
  input  logic [1:0]    pts,
  input  logic [SW-1:0] fs,
  input  logic [FW-1:0] f_in,
  output logic [FW-1:0] f_hz
);
  import fmcw_rv_pkg::*;

  localparam int PW = FW + SW;

  logic [PW-1:0] prod;
  logic [PW-1:0] shifted;
  logic [FW-1:0] conv;

  always_comb begin
    prod    = PW'(f_in) * PW'(fs);
    shifted = prod >> pts_shift(pts);
    if (!bin_mode)
      conv = f_in;
    else if (|shifted[PW-1:FW])
      conv = {FW{1'b1}};
    else
      conv = shifted[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      f_hz <= '0;
    else if (en)
      f_hz <= conv;
  end
endmodule

// File: rtl/fmcw_pair_combine.sv
// Stage 2: sum, signed difference and equality of the two beats
module fmcw_pair_combine #(
  parameter int FW = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [FW-1:0]       f_up,
  input  logic [FW-1:0]       f_dn,
  output logic [FW:0]         sum,
  output logic signed [FW:0]  diff,
  output logic                same
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      diff <= '0;
      same <= 1'b0;
    end else if (en) begin
      sum  <= {1'b0, f_up} + {1'b0, f_dn};
      diff <= $signed({1'b0, f_dn}) - $signed({1'b0, f_up});
      same <= (f_up == f_dn);
    end
  end
endmodule

// File: rtl/fmcw_scale_out.sv
// Stage 3: scaling by reciprocal constants with saturation
module fmcw_scale_out #(
  parameter int FW    = 20,
  parameter int CW    = 24,
  parameter int RFRAC = 16,
  parameter int VFRAC = 16,
  parameter int RW    = 16,
  parameter int VW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [FW:0]          sum,
  input  logic signed [FW:0]   diff,
  input  logic                 same,
  input  logic [CW-1:0]        range_k,
  input  logic [CW-1:0]        vel_k,
  output logic [RW-1:0]        range_o,
  output logic signed [VW-1:0] vel_o,
  output logic                 still_o
);
  localparam int RPW = FW + 1 + CW;
  localparam int VPW = FW + 2 + CW;

  logic [RPW-1:0]        rprod;
  logic [RPW-1:0]        rsh;
  logic [RW-1:0]         range_n;
  logic signed [VPW-1:0] vprod;
  logic signed [VPW-1:0] vsh;
  logic signed [VW-1:0]  vel_n;
  logic                  vfits;

  always_comb begin
    // the division by two of the mean folds into the shift
    rprod = RPW'(sum) * RPW'(range_k);
    rsh   = rprod >> (RFRAC + 1);
    range_n = (|rsh[RPW-1:RW]) ? {RW{1'b1}} : rsh[RW-1:0];

    vprod = VPW'(diff) * $signed({{(VPW-CW){1'b0}}, vel_k});
    vsh   = vprod >>> (VFRAC + 1);
    vfits = (&vsh[VPW-1:VW-1]) || !(|vsh[VPW-1:VW-1]);
    if (vfits)
      vel_n = vsh[VW-1:0];
    else if (vsh[VPW-1])
      vel_n = {1'b1, {(VW-1){1'b0}}};
    else
      vel_n = {1'b0, {(VW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      range_o <= '0;
      vel_o   <= '0;
      still_o <= 1'b0;
    end else if (en) begin
      range_o <= range_n;
      vel_o   <= vel_n;
      still_o <= same;
    end
  end
endmodule

// File: rtl/fmcw_range_vel.sv
module fmcw_range_vel #(
  parameter int FW    = 20,
  parameter int SW    = 24,
  parameter int CW    = 24,
  parameter int RFRAC = 16,
  parameter int VFRAC = 16,
  parameter int RW    = 16,
  parameter int VW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FW-1:0]        in_f_up,
  input  logic [FW-1:0]        in_f_dn,
  input  logic                 cfg_bin_mode,
  input  logic [1:0]           cfg_pts,
  input  logic [SW-1:0]        cfg_fs,
  input  logic [CW-1:0]        cfg_range_k,
  input  logic [CW-1:0]        cfg_vel_k,
  output logic                 out_valid,
  output logic [RW-1:0]        out_range,
  output logic signed [VW-1:0] out_vel,
  output logic                 out_still
);
  localparam int LANES = 2;

  logic                accept;
  logic                v1, v2;
  logic [FW-1:0]       lane_in [LANES];
  logic [FW-1:0]       lane_hz [LANES];
  logic [CW-1:0]       rk1, vk1, rk2, vk2;
  logic [FW:0]         sum2;
  logic signed [FW:0]  diff2;
  logic                same2;

  assign accept     = in_valid && in_ready;
  assign lane_in[0] = in_f_up;
  assign lane_in[1] = in_f_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      v1        <= accept;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  // scale constants follow their pair down the pipe
  always_ff @(posedge clk) begin
    if (rst) begin
      rk1 <= '0; vk1 <= '0; rk2 <= '0; vk2 <= '0;
    end else begin
      if (accept) begin
        rk1 <= cfg_range_k;
        vk1 <= cfg_vel_k;
      end
      if (v1) begin
        rk2 <= rk1;
        vk2 <= vk1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmcw_bin_conv #(.FW(FW), .SW(SW)) u_conv (
      .clk(clk), .rst(rst), .en(accept),
      .bin_mode(cfg_bin_mode), .pts(cfg_pts), .fs(cfg_fs),
      .f_in(lane_in[g]), .f_hz(lane_hz[g])
    );
  end

  fmcw_pair_combine #(.FW(FW)) u_comb (
    .clk(clk), .rst(rst), .en(v1),
    .f_up(lane_hz[0]), .f_dn(lane_hz[1]),
    .sum(sum2), .diff(diff2), .same(same2)
  );

  fmcw_scale_out #(
    .FW(FW), .CW(CW), .RFRAC(RFRAC), .VFRAC(VFRAC), .RW(RW), .VW(VW)
  ) u_scale (
    .clk(clk), .rst(rst), .en(v2),
    .sum(sum2), .diff(diff2), .same(same2),
    .range_k(rk2), .vel_k(vk2),
    .range_o(out_range), .vel_o(out_vel), .still_o(out_still)
  );
endmodule

// File: rtl/fmcw_range_vel_chk.sv
module fmcw_range_vel_chk #(
  parameter int FW = 20,
  parameter int RW = 16,
  parameter int VW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [FW-1:0]        in_f_up,
  input logic [FW-1:0]        in_f_dn,
  input logic                 out_valid,
  input logic [RW-1:0]        out_range,
  input logic signed [VW-1:0] out_vel,
  input logic                 out_still
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!in_ready && !out_valid && out_range == '0 && out_vel == '0 && !out_still));

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == ($past(in_valid && in_ready, 3) && !$past(rst, 2) && !$past(rst, 1)));

  p_vel_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_vel[VW-1]) |-> ($past(in_f_dn, 3) < $past(in_f_up, 3)));

  p_still_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_still) |-> (out_vel == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_range) && $stable(out_vel) && $stable(out_still)));
endmodule

bind fmcw_range_vel fmcw_range_vel_chk #(.FW(FW), .RW(RW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_f_up(in_f_up), .in_f_dn(in_f_dn), .out_valid(out_valid),
  .out_range(out_range), .out_vel(out_vel), .out_still(out_still)
);

// File: tb/fmcw_range_vel_bench.sv
`timescale 1ns/1ps
module fmcw_range_vel_bench;
  localparam int FW = 20, SW = 24, CW = 24, RFRAC = 16, VFRAC = 16, RW = 16, VW = 16;
  localparam int NV = 12;

  // stimulus table and expected stationary flag
  localparam longint T_MODE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
  localparam longint T_PTS  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 3, 0, 0};
  localparam longint T_FS   [NV] = '{0, 0, 0, 0, 0, 0, 2000000, 2000000, 10000000, 10000000, 16777215, 0};
  localparam longint T_UP   [NV] = '{200000, 150000, 160000, 1048575, 0, 1048575, 100, 300, 819, 819, 1048575, 0};
  localparam longint T_DN   [NV] = '{200000, 160000, 150000, 1048575, 1048575, 0, 101, 300, 817, 817, 5, 0};
  localparam longint T_RK   [NV] = '{1053, 1053, 1053, 16777215, 1053, 1053, 1053, 1053, 1053, 1053, 1053, 1053};
  localparam longint T_VK   [NV] = '{12780, 12780, 12780, 12780, 16777215, 16777215, 12780, 12780, 12780, 12780, 12780, 12780};
  localparam longint T_STILL[NV] = '{1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [FW-1:0] in_f_up = '0, in_f_dn = '0;
  logic cfg_bin_mode = 1'b0;
  logic [1:0] cfg_pts = '0;
  logic [SW-1:0] cfg_fs = '0;
  logic [CW-1:0] cfg_range_k = '0, cfg_vel_k = '0;
  logic out_valid;
  logic [RW-1:0] out_range;
  logic signed [VW-1:0] out_vel;
  logic out_still;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fmcw_range_vel #(.FW(FW), .SW(SW), .CW(CW), .RFRAC(RFRAC), .VFRAC(VFRAC), .RW(RW), .VW(VW))
  u_fmcw_range_vel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_f_up(in_f_up), .in_f_dn(in_f_dn), .cfg_bin_mode(cfg_bin_mode),
    .cfg_pts(cfg_pts), .cfg_fs(cfg_fs), .cfg_range_k(cfg_range_k),
    .cfg_vel_k(cfg_vel_k), .out_valid(out_valid), .out_range(out_range),
    .out_vel(out_vel), .out_still(out_still)
  );

  function automatic longint conv(longint mode, longint pts, longint fs, longint f);
    longint p;
    if (mode == 0) return f;
    p = (f * fs) >> ((pts == 0) ? 11 : (pts == 1) ? 12 : 13);
    if (p > (64'sd1 << FW) - 1) p = (64'sd1 << FW) - 1;
    return p;
  endfunction

  function automatic longint exp_range(longint u, longint d, longint rk);
    longint r;
    r = ((u + d) * rk) >>> (RFRAC + 1);
    if (r > (64'sd1 << RW) - 1) r = (64'sd1 << RW) - 1;
    return r;
  endfunction

  function automatic longint exp_vel(longint u, longint d, longint vk);
    longint v;
    v = ((d - u) * vk) >>> (VFRAC + 1);
    if (v > (64'sd1 << (VW - 1)) - 1) v = (64'sd1 << (VW - 1)) - 1;
    if (v < -(64'sd1 << (VW - 1))) v = -(64'sd1 << (VW - 1));
    return v;
  endfunction

  task automatic check(string tag, longint act, longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(int i);
    in_valid     = 1'b1;
    cfg_bin_mode = T_MODE[i][0];
    cfg_pts      = T_PTS[i][1:0];
    cfg_fs       = SW'(T_FS[i]);
    in_f_up      = FW'(T_UP[i]);
    in_f_dn      = FW'(T_DN[i]);
    cfg_range_k  = CW'(T_RK[i]);
    cfg_vel_k    = CW'(T_VK[i]);
  endtask

  task automatic check_result(int i, string tag);
    longint u, d;
    u = conv(T_MODE[i], T_PTS[i], T_FS[i], T_UP[i]);
    d = conv(T_MODE[i], T_PTS[i], T_FS[i], T_DN[i]);
    check({tag, " R2 out_valid"}, longint'(out_valid), 1);
    check({tag, " R3/R4 range"}, longint'(out_range), exp_range(u, d, T_RK[i]));
    check({tag, " R3/R5 velocity"}, longint'(out_vel), exp_vel(u, d, T_VK[i]));
    check({tag, " R6 still"}, longint'(out_still), T_STILL[i]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    longint held_r, held_v;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 in_ready in reset", longint'(in_ready), 0);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    check("R1 out_range in reset", longint'(out_range), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready after reset", longint'(in_ready), 1);

    // table walk, one pair at a time, R2 latency exact
    for (int i = 0; i < NV; i++) begin
      drive(i);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("vec%0d R2 early1", i), longint'(out_valid), 0);
      @(negedge clk);
      check($sformatf("vec%0d R2 early2", i), longint'(out_valid), 0);
      @(negedge clk);
      check_result(i, $sformatf("vec%0d", i));
      @(negedge clk);
      check($sformatf("vec%0d R2 single pulse", i), longint'(out_valid), 0);
    end

    // R8: outputs hold while idle
    held_r = longint'(out_range);
    held_v = longint'(out_vel);
    in_f_up = 20'd5; in_f_dn = 20'd900;
    repeat (4) @(negedge clk);
    check("R8 range held", longint'(out_range), held_r);
    check("R8 velocity held", longint'(out_vel), held_v);

    // R2: back-to-back pairs
    drive(1); @(negedge clk);
    drive(2); @(negedge clk);
    drive(6); @(negedge clk);
    in_valid = 1'b0;
    check_result(1, "b2b first");
    @(negedge clk);
    check_result(2, "b2b second");
    @(negedge clk);
    check_result(6, "b2b third");
    @(negedge clk);
    check("R2 b2b end", longint'(out_valid), 0);

    // R7: configuration changed after acceptance
    drive(8); @(negedge clk);
    in_valid = 1'b0;
    cfg_bin_mode = 1'b0; cfg_pts = 2'd0; cfg_fs = '0;
    cfg_range_k = '0; cfg_vel_k = '0;
    @(negedge clk);
    cfg_range_k = 24'd999; cfg_vel_k = 24'd7;
    @(negedge clk);
    check_result(8, "R7 cfg captured");
    @(negedge clk);

    // R1/R2: reset while a pair is in flight
    drive(4); @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 cleared range", longint'(out_range), 0);
    check("R1 cleared velocity", longint'(out_vel), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check($sformatf("R2 cancelled result %0d", k), longint'(out_valid), 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule